// File: doc/BRIEF.md
# SPI FIFO Flag and Interrupt Unit

This unit sits next to the transmit and receive FIFOs of an SPI controller and turns what happens around them into flags. It samples the two FIFO fill levels, the engine's busy indication, the bus-side write strobe to the transmit data port, the bus-side read strobe from the receive data port and the engine-side push into the receive FIFO. From these it produces a five-bit status word, a five-bit raw interrupt vector, the masked copy of that vector, one combined interrupt line, and a transmit and a receive DMA request.

Software programs four thresholds: one for the transmit interrupt, one for the receive interrupt, and one for each DMA direction. It also programs an interrupt mask, a two-bit DMA enable and a write-to-clear register for the sticky error bits. A threshold write whose value is not below the FIFO depth is dropped. Software can therefore find the depth by writing rising values and reading each one back. Every output is a flop, so it reflects the inputs sampled at the previous rising clock edge.

Top module: `spi_fifo_flags`

## Requirements
- R1: The status word, one cycle after the inputs, holds engine busy in bit 0, transmit full (level equals DEPTH) in bit 1, transmit empty (level 0) in bit 2, receive empty in bit 3 and receive full in bit 4.
- R2: Raw bit 0 is set while the transmit level is at or below the transmit interrupt threshold. Raw bit 4 is set while the receive level is above the receive interrupt threshold. Both follow the levels and are not sticky.
- R3: A bus write while the transmit level equals DEPTH sets raw bit 1, which then stays set. A write below full leaves it clear.
- R4: A bus read while the receive level is 0 sets raw bit 2, which then stays set.
- R5: An engine push while the receive level equals DEPTH sets raw bit 3, which then stays set.
- R6: A clear write acts on the sticky bits as follows. Data bit 0 clears all three. Bit 1 clears raw bit 2, bit 2 clears raw bit 3 and bit 3 clears raw bit 1. A set in the same cycle wins over a clear.
- R7: A threshold write with a value at or above DEPTH is ignored and the read-back keeps the old value. A value below DEPTH is taken.
- R8: The masked vector equals the raw vector ANDed with the mask written through mask_wr, bits 4..0. The interrupt line is the OR of the masked bits.
- R9: The transmit DMA request is high while enable bit 1 is set and the transmit level is at or below the transmit DMA threshold. The receive DMA request is high while enable bit 0 is set and the receive level is above the receive DMA threshold.
- R10: After reset all thresholds, the mask, the DMA enables and the sticky bits are 0, and every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eng_busy | input | 1 | Serial engine is shifting |
| tx_level | input | LVL_W | Transmit FIFO fill level |
| rx_level | input | LVL_W | Receive FIFO fill level |
| bus_tx_wr | input | 1 | Bus write to the transmit data port |
| bus_rx_rd | input | 1 | Bus read from the receive data port |
| eng_rx_push | input | 1 | Engine push into the receive FIFO |
| thr_wr | input | 1 | Threshold write strobe |
| thr_sel | input | 2 | Threshold select: 0 tx irq, 1 rx irq, 2 tx DMA, 3 rx DMA |
| mask_wr | input | 1 | Interrupt mask write strobe |
| dma_ctl_wr | input | 1 | DMA enable write strobe |
| clr_wr | input | 1 | Clear register write strobe |
| cfg_wdata | input | WDATA_W | Write data shared by all configuration strobes |
| status | output | 5 | Status word |
| raw_irq | output | 5 | Raw interrupt vector |
| masked_irq | output | 5 | Raw vector ANDed with the mask |
| irq | output | 1 | OR of the masked vector |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_irq_th | output | TH_W | Read-back of the transmit interrupt threshold |
| rx_irq_th | output | TH_W | Read-back of the receive interrupt threshold |
| tx_dma_th | output | TH_W | Read-back of the transmit DMA threshold |
| rx_dma_th | output | TH_W | Read-back of the receive DMA threshold |

## Verification
Levels are driven at empty, full and mid-range values. This separates the empty and full flags from each other and from the threshold compares. The transmit level is also placed exactly on its threshold and one above it, which exposes off-by-one errors in the "at or below" and "above" compares. Each error strobe is fired once at the triggering level and once just short of it, and each clear bit is exercised alone. This shows both the set condition and that each clear bit reaches only its own sticky bit. A depth-discovery loop of threshold writes confirms that out-of-range values are rejected at exactly DEPTH.

// File: rtl/spi_ff_pkg.sv
package spi_ff_pkg;
  // status word bit positions
  localparam int ST_BUSY    = 0;
  localparam int ST_TXFULL  = 1;
  localparam int ST_TXEMPTY = 2;
  localparam int ST_RXEMPTY = 3;
  localparam int ST_RXFULL  = 4;
  // interrupt vector bit positions (raw, masked, mask)
  localparam int IRQ_TXE   = 0;
  localparam int IRQ_TXOVF = 1;
  localparam int IRQ_RXUDF = 2;
  localparam int IRQ_RXOVF = 3;
  localparam int IRQ_RXF   = 4;
  // clear register bit positions
  localparam int CLR_ALL   = 0;
  localparam int CLR_RXUDF = 1;
  localparam int CLR_RXOVF = 2;
  localparam int CLR_TXOVF = 3;
  // DMA enable bits
  localparam int DMA_RX_EN = 0;
  localparam int DMA_TX_EN = 1;

  localparam int NUM_THR    = 4;
  localparam int NUM_STICKY = 3;

  typedef enum logic [1:0] {
    THR_TX_IRQ = 2'd0,
    THR_RX_IRQ = 2'd1,
    THR_TX_DMA = 2'd2,
    THR_RX_DMA = 2'd3
  } thr_sel_e;

  // sticky slot k drives raw bit k+1; its private clear bit:
  function automatic int clr_bit_of(input int k);
    case (k)
      0:       return CLR_TXOVF;
      1:       return CLR_RXUDF;
      default: return CLR_RXOVF;
    endcase
  endfunction
endpackage

// File: rtl/spi_thr_reg.sv
module spi_thr_reg #(
  parameter int DEPTH   = 16,
  parameter int WDATA_W = 8,
  localparam int TH_W   = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr,
  input  logic [WDATA_W-1:0] wdata,
  output logic [TH_W-1:0]    q
);
  localparam logic [WDATA_W-1:0] LIMIT = WDATA_W'(DEPTH);

  logic in_range;
  assign in_range = (wdata < LIMIT);

  always_ff @(posedge clk) begin
    if (rst)                 q <= '0;
    else if (wr && in_range) q <= wdata[TH_W-1:0];
  end

  // R7: an out-of-range write leaves the value alone
  p_thr_ignore_r7: assert property (@(posedge clk) disable iff (rst)
    (wr && !in_range) |=> $stable(q));
  // R7: an in-range write lands
  p_thr_take_r7: assert property (@(posedge clk) disable iff (rst)
    (wr && in_range) |=> (q == $past(wdata[TH_W-1:0])));
endmodule

// File: rtl/spi_sticky_bit.sv
module spi_sticky_bit (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_d,
  output logic flag_q
);
  // set has priority so an event in the clearing cycle is not lost
  assign flag_d = set_i | (flag_q & ~clr_i);

  always_ff @(posedge clk) begin
    if (rst) flag_q <= 1'b0;
    else     flag_q <= flag_d;
  end

  p_sticky_set_r6: assert property (@(posedge clk) disable iff (rst)
    set_i |=> flag_q);
  p_sticky_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !clr_i) |=> flag_q);
  p_sticky_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !flag_q);
endmodule

// File: rtl/spi_level_decode.sv
module spi_level_decode #(
  parameter int DEPTH  = 16,
  localparam int LVL_W = $clog2(DEPTH+1),
  localparam int TH_W  = $clog2(DEPTH)
) (
  input  logic             eng_busy,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [TH_W-1:0]  tx_irq_th,
  input  logic [TH_W-1:0]  rx_irq_th,
  input  logic [TH_W-1:0]  tx_dma_th,
  input  logic [TH_W-1:0]  rx_dma_th,
  input  logic [1:0]       dma_en,
  output logic [4:0]       status_d,
  output logic             tx_full,
  output logic             rx_full,
  output logic             rx_empty,
  output logic             txe_d,
  output logic             rxf_d,
  output logic             tx_dreq_d,
  output logic             rx_dreq_d
);
  import spi_ff_pkg::*;
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  logic tx_empty;

  always_comb begin
    tx_full  = (tx_level == FULL_LVL);
    tx_empty = (tx_level == '0);
    rx_full  = (rx_level == FULL_LVL);
    rx_empty = (rx_level == '0);

    status_d             = '0;
    status_d[ST_BUSY]    = eng_busy;
    status_d[ST_TXFULL]  = tx_full;
    status_d[ST_TXEMPTY] = tx_empty;
    status_d[ST_RXEMPTY] = rx_empty;
    status_d[ST_RXFULL]  = rx_full;

    txe_d     = (tx_level <= LVL_W'(tx_irq_th));
    rxf_d     = (rx_level >  LVL_W'(rx_irq_th));
    tx_dreq_d = dma_en[DMA_TX_EN] && (tx_level <= LVL_W'(tx_dma_th));
    rx_dreq_d = dma_en[DMA_RX_EN] && (rx_level >  LVL_W'(rx_dma_th));
  end
endmodule

// File: rtl/spi_fifo_flags.sv
module spi_fifo_flags
  import spi_ff_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int WDATA_W = 8,
  localparam int LVL_W  = $clog2(DEPTH+1),
  localparam int TH_W   = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               eng_busy,
  input  logic [LVL_W-1:0]   tx_level,
  input  logic [LVL_W-1:0]   rx_level,
  input  logic               bus_tx_wr,
  input  logic               bus_rx_rd,
  input  logic               eng_rx_push,
  input  logic               thr_wr,
  input  logic [1:0]         thr_sel,
  input  logic               mask_wr,
  input  logic               dma_ctl_wr,
  input  logic               clr_wr,
  input  logic [WDATA_W-1:0] cfg_wdata,
  output logic [4:0]         status,
  output logic [4:0]         raw_irq,
  output logic [4:0]         masked_irq,
  output logic               irq,
  output logic               tx_dma_req,
  output logic               rx_dma_req,
  output logic [TH_W-1:0]    tx_irq_th,
  output logic [TH_W-1:0]    rx_irq_th,
  output logic [TH_W-1:0]    tx_dma_th,
  output logic [TH_W-1:0]    rx_dma_th
);
  // ---------------- threshold registers ----------------
  logic [TH_W-1:0] thr_q [NUM_THR];

  for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
    spi_thr_reg #(.DEPTH(DEPTH), .WDATA_W(WDATA_W)) u_thr (
      .clk   (clk),
      .rst   (rst),
      .wr    (thr_wr && (thr_sel == 2'(t))),
      .wdata (cfg_wdata),
      .q     (thr_q[t])
    );
  end

  assign tx_irq_th = thr_q[THR_TX_IRQ];
  assign rx_irq_th = thr_q[THR_RX_IRQ];
  assign tx_dma_th = thr_q[THR_TX_DMA];
  assign rx_dma_th = thr_q[THR_RX_DMA];

  // ---------------- mask and DMA enable ----------------
  logic [4:0] mask_q, mask_d;
  logic [1:0] dma_en_q, dma_en_d;

  assign mask_d   = mask_wr    ? cfg_wdata[4:0] : mask_q;
  assign dma_en_d = dma_ctl_wr ? cfg_wdata[1:0] : dma_en_q;

  // ---------------- level decode ----------------
  logic [4:0] status_d;
  logic tx_full, rx_full, rx_empty, txe_d, rxf_d, tx_dreq_d, rx_dreq_d;

  spi_level_decode #(.DEPTH(DEPTH)) u_dec (
    .eng_busy  (eng_busy),
    .tx_level  (tx_level),
    .rx_level  (rx_level),
    .tx_irq_th (thr_q[THR_TX_IRQ]),
    .rx_irq_th (thr_q[THR_RX_IRQ]),
    .tx_dma_th (thr_q[THR_TX_DMA]),
    .rx_dma_th (thr_q[THR_RX_DMA]),
    .dma_en    (dma_en_d),
    .status_d  (status_d),
    .tx_full   (tx_full),
    .rx_full   (rx_full),
    .rx_empty  (rx_empty),
    .txe_d     (txe_d),
    .rxf_d     (rxf_d),
    .tx_dreq_d (tx_dreq_d),
    .rx_dreq_d (rx_dreq_d)
  );

  // ---------------- sticky error bits ----------------
  logic [NUM_STICKY-1:0] stk_set, stk_clr, stk_d, stk_q;

  assign stk_set[0] = bus_tx_wr   & tx_full;   // transmit overflow
  assign stk_set[1] = bus_rx_rd   & rx_empty;  // receive underflow
  assign stk_set[2] = eng_rx_push & rx_full;   // receive overflow

  for (genvar k = 0; k < NUM_STICKY; k++) begin : g_stk
    assign stk_clr[k] = clr_wr & (cfg_wdata[CLR_ALL] | cfg_wdata[clr_bit_of(k)]);
    spi_sticky_bit u_stk (
      .clk    (clk),
      .rst    (rst),
      .set_i  (stk_set[k]),
      .clr_i  (stk_clr[k]),
      .flag_d (stk_d[k]),
      .flag_q (stk_q[k])
    );
  end

  // ---------------- output registers ----------------
  logic [4:0] raw_d;
  always_comb begin
    raw_d            = '0;
    raw_d[IRQ_TXE]   = txe_d;
    raw_d[IRQ_TXOVF] = stk_d[0];
    raw_d[IRQ_RXUDF] = stk_d[1];
    raw_d[IRQ_RXOVF] = stk_d[2];
    raw_d[IRQ_RXF]   = rxf_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q     <= '0;
      dma_en_q   <= '0;
      status     <= '0;
      raw_irq    <= '0;
      masked_irq <= '0;
      irq        <= 1'b0;
      tx_dma_req <= 1'b0;
      rx_dma_req <= 1'b0;
    end else begin
      mask_q     <= mask_d;
      dma_en_q   <= dma_en_d;
      status     <= status_d;
      raw_irq    <= raw_d;
      masked_irq <= raw_d & mask_d;
      irq        <= |(raw_d & mask_d);
      tx_dma_req <= tx_dreq_d;
      rx_dma_req <= rx_dreq_d;
    end
  end

  // ---------------- assertions ----------------
  p_status_txfull_r1: assert property (@(posedge clk) disable iff (rst)
    (tx_level == LVL_W'(DEPTH)) |=> status[ST_TXFULL]);
  p_status_busy_r1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (status[ST_BUSY] == $past(eng_busy)));
  p_txe_level_r2: assert property (@(posedge clk) disable iff (rst)
    (tx_level > LVL_W'(thr_q[THR_TX_IRQ])) |=> !raw_irq[IRQ_TXE]);
  p_txovf_set_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_tx_wr && tx_level == LVL_W'(DEPTH)) |=> raw_irq[IRQ_TXOVF]);
  p_rxudf_set_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_rx_rd && rx_level == '0) |=> raw_irq[IRQ_RXUDF]);
  p_rxovf_set_r5: assert property (@(posedge clk) disable iff (rst)
    (eng_rx_push && rx_level == LVL_W'(DEPTH)) |=> raw_irq[IRQ_RXOVF]);
  p_mask_and_r8: assert property (@(posedge clk) disable iff (rst)
    (masked_irq == (raw_irq & mask_q)));
  p_irq_line_r8: assert property (@(posedge clk) disable iff (rst)
    (irq == (|masked_irq)));
  p_txdma_r9: assert property (@(posedge clk) disable iff (rst)
    (!dma_en_d[DMA_TX_EN]) |=> !tx_dma_req);
  p_rxdma_r9: assert property (@(posedge clk) disable iff (rst)
    (!dma_en_d[DMA_RX_EN]) |=> !rx_dma_req);
endmodule

// File: tb/spi_fifo_flags_bench.sv
`timescale 1ns/1ps
module spi_fifo_flags_bench;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic eng_busy = 1'b0;
  logic [4:0] tx_level = '0, rx_level = '0;
  logic bus_tx_wr = 1'b0, bus_rx_rd = 1'b0, eng_rx_push = 1'b0;
  logic thr_wr = 1'b0, mask_wr = 1'b0, dma_ctl_wr = 1'b0, clr_wr = 1'b0;
  logic [1:0] thr_sel = '0;
  logic [7:0] cfg_wdata = '0;
  logic [4:0] status, raw_irq, masked_irq;
  logic irq, tx_dma_req, rx_dma_req;
  logic [3:0] tx_irq_th, rx_irq_th, tx_dma_th, rx_dma_th;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  spi_fifo_flags #(.DEPTH(DEPTH), .WDATA_W(8)) u_spi_fifo_flags (
    .clk(clk), .rst(rst), .eng_busy(eng_busy),
    .tx_level(tx_level), .rx_level(rx_level),
    .bus_tx_wr(bus_tx_wr), .bus_rx_rd(bus_rx_rd), .eng_rx_push(eng_rx_push),
    .thr_wr(thr_wr), .thr_sel(thr_sel), .mask_wr(mask_wr),
    .dma_ctl_wr(dma_ctl_wr), .clr_wr(clr_wr), .cfg_wdata(cfg_wdata),
    .status(status), .raw_irq(raw_irq), .masked_irq(masked_irq), .irq(irq),
    .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req),
    .tx_irq_th(tx_irq_th), .rx_irq_th(rx_irq_th),
    .tx_dma_th(tx_dma_th), .rx_dma_th(rx_dma_th)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_thr(input logic [1:0] sel, input logic [7:0] v);
    thr_sel = sel; cfg_wdata = v; thr_wr = 1'b1;
    step(1); thr_wr = 1'b0;
  endtask

  task automatic wr_mask(input logic [4:0] v);
    cfg_wdata = {3'b0, v}; mask_wr = 1'b1; step(1); mask_wr = 1'b0;
  endtask

  task automatic wr_dma(input logic [1:0] v);
    cfg_wdata = {6'b0, v}; dma_ctl_wr = 1'b1; step(1); dma_ctl_wr = 1'b0;
  endtask

  task automatic wr_clr(input logic [3:0] v);
    cfg_wdata = {4'b0, v}; clr_wr = 1'b1; step(1); clr_wr = 1'b0;
  endtask

  task automatic t_reset;
    chk("R10 status", status, 0);
    chk("R10 raw", raw_irq, 0);
    chk("R10 irq", irq, 0);
    chk("R10 dma", {tx_dma_req, rx_dma_req}, 0);
    chk("R10 thresholds", {tx_irq_th, rx_irq_th, tx_dma_th, rx_dma_th}, 0);
  endtask

  task automatic t_status;
    tx_level = 0; rx_level = 0; eng_busy = 0; step(1);
    chk("R1 both empty", status, 5'b01100);
    tx_level = 16; rx_level = 16; eng_busy = 1; step(1);
    chk("R1 both full busy", status, 5'b10011);
    tx_level = 5; rx_level = 7; eng_busy = 0; step(1);
    chk("R1 mid levels", status, 5'b00000);
  endtask

  task automatic t_thresh;
    int found;
    wr_thr(2'd0, 8);  chk("R7 take 8", tx_irq_th, 8);
    wr_thr(2'd0, 16); chk("R7 ignore 16", tx_irq_th, 8);
    wr_thr(2'd0, 15); chk("R7 take 15", tx_irq_th, 15);
    wr_thr(2'd1, 3);  wr_thr(2'd1, 200);
    chk("R7 ignore 200", rx_irq_th, 3);
    found = 0;
    for (int i = 1; i < 40; i++) begin
      wr_thr(2'd2, 8'(i));
      if (found == 0 && int'(tx_dma_th) != i) found = i;
    end
    chk("R7 depth discovery", found, DEPTH);
  endtask

  task automatic t_level_irq;
    wr_thr(2'd0, 8); wr_thr(2'd1, 3);
    tx_level = 8; rx_level = 3; step(2);
    chk("R2 tx at threshold", raw_irq[0], 1);
    chk("R2 rx at threshold", raw_irq[4], 0);
    tx_level = 9; rx_level = 4; step(1);
    chk("R2 tx above threshold not sticky", raw_irq[0], 0);
    chk("R2 rx above threshold", raw_irq[4], 1);
  endtask

  task automatic t_sticky;
    tx_level = 15; rx_level = 5;
    bus_tx_wr = 1; bus_rx_rd = 1; eng_rx_push = 1; step(1);
    bus_tx_wr = 0; bus_rx_rd = 0; eng_rx_push = 0;
    chk("R3 R4 R5 no set short of trigger", raw_irq[3:1], 3'b000);
    tx_level = 16; bus_tx_wr = 1; step(1); bus_tx_wr = 0; tx_level = 3;
    chk("R3 tx overflow set", raw_irq[1], 1);
    rx_level = 0; bus_rx_rd = 1; step(1); bus_rx_rd = 0;
    chk("R4 rx underflow set", raw_irq[2], 1);
    rx_level = 16; eng_rx_push = 1; step(1); eng_rx_push = 0; rx_level = 5;
    step(2);
    chk("R5 rx overflow set and all held", raw_irq[3:1], 3'b111);
    wr_clr(4'b1000); chk("R6 clear bit3 -> tx overflow", raw_irq[3:1], 3'b110);
    wr_clr(4'b0010); chk("R6 clear bit1 -> rx underflow", raw_irq[3:1], 3'b100);
    wr_clr(4'b0100); chk("R6 clear bit2 -> rx overflow", raw_irq[3:1], 3'b000);
    tx_level = 16; bus_tx_wr = 1; rx_level = 0; bus_rx_rd = 1; step(1);
    bus_tx_wr = 0; bus_rx_rd = 0; rx_level = 16; eng_rx_push = 1; step(1);
    eng_rx_push = 0; rx_level = 5; tx_level = 3;
    chk("R6 all three set", raw_irq[3:1], 3'b111);
    wr_clr(4'b0001); chk("R6 clear-all", raw_irq[3:1], 3'b000);
    tx_level = 16; bus_tx_wr = 1; cfg_wdata = 8'h09; clr_wr = 1; step(1);
    bus_tx_wr = 0; clr_wr = 0; tx_level = 3;
    chk("R6 set wins over clear", raw_irq[1], 1);
  endtask

  task automatic t_mask;
    wr_mask(5'b00010);
    chk("R8 masked picks tx overflow", masked_irq, 5'b00010);
    chk("R8 irq line high", irq, 1);
    wr_mask(5'b00000);
    chk("R8 mask off irq low", irq, 0);
    wr_clr(4'b0001);
    rx_level = 4; wr_mask(5'b10000); step(1);
    chk("R8 masked rx full", masked_irq, 5'b10000);
    wr_mask(5'b00000);
  endtask

  task automatic t_dma;
    wr_thr(2'd2, 4); wr_thr(2'd3, 4);
    tx_level = 2; rx_level = 5; wr_dma(2'b00); step(1);
    chk("R9 disabled no requests", {tx_dma_req, rx_dma_req}, 2'b00);
    wr_dma(2'b10); step(1);
    chk("R9 tx enabled at level 2", {tx_dma_req, rx_dma_req}, 2'b10);
    wr_dma(2'b11); step(1);
    chk("R9 both enabled", {tx_dma_req, rx_dma_req}, 2'b11);
    tx_level = 5; rx_level = 4; step(1);
    chk("R9 levels past thresholds", {tx_dma_req, rx_dma_req}, 2'b00);
    tx_level = 4; step(1);
    chk("R9 tx at threshold", tx_dma_req, 1);
  endtask

  initial begin
    step(3);
    rst = 1'b0;
    t_reset();
    t_status();
    t_thresh();
    t_level_irq();
    t_sticky();
    t_mask();
    t_dma();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule